// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This block decides which parts of a communications terminal are powered at any moment. Software selects one of four operating levels through a small register interface: full operation with audio processing, operation without the audio processor, a low-power idle level in which only the processor interface and the line interface stay alive, and a power-down level in which the clocks are stopped. The block turns the selected level into enable lines for each functional sub-block, a run/hold control for the processor clock and a run/stop control for the crystal oscillator.

Power-down is guarded. The request is honoured only when a separate enable flag has been written, and it starts a countdown that gives the processor time to finish its work. A low interrupt line during that countdown cancels it. When the countdown ends while the line interface is still busy, the processor clock stops first and the oscillator keeps running until the line settles or completes activation. Wake events arrive on asynchronous pins and pass through two-flop synchronisers before they affect the sequencer.

Top module: `psq_power_seq`

## Requirements
- R1: After reset the mode status is 01 (idle), the processor clock, oscillator, register-interface and line-interface enables are 1, the multiplexer, data-link and audio enables are 0, and the serial-port drive enable is 0.
- R2: A mode write outside power-down selects code 11 (all enables 1), code 10 (audio enable 0, others 1) or code 01 (idle), and the status output shows the written code.
- R3: Each entry into idle from another level gives a pulse of exactly one cycle on the data-link status clear output; staying in idle gives none.
- R4: A mode write of code 00 while the power-down enable flag (written through the configuration port) is 0 is ignored and the level is unchanged.
- R5: With the flag set, code 00 starts a countdown; the status shows 00 and the processor clock keeps running for exactly 2**CNT_W cycles, after which the processor clock is held and, if the line interface is disabled or in its deactivated state, the oscillator stops too.
- R6: A low interrupt line during the countdown cancels it and returns the block to idle.
- R7: If the line interface is enabled and not deactivated when the countdown ends, only the processor clock stops; the oscillator stops one cycle after the line interface reports the deactivated state.
- R8: If line activation completes while only the processor clock is stopped, the activation interrupt output pulses for one cycle and the block returns to idle.
- R9: In power-down, chip-select and write strobe both low wake the block to idle; either one low on its own does not.
- R10: In power-down, a change of the hookswitch pin wakes the block to idle only while the hookswitch interrupt enable is 1.
- R11: The serial-port drive enable stays 0 until the first multiplexer connection write and then stays 1 until reset.
- R12: Mode writes during the countdown or in power-down have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_code | input | 2 | Requested level: 00 power-down, 01 idle, 10 data only, 11 voice and data |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_pd_en | input | 1 | Power-down enable flag written on cfg_wr |
| mux_conn_wr | input | 1 | Pulse when a multiplexer connection is programmed |
| cs_n | input | 1 | Asynchronous chip-select, active low |
| wr_n | input | 1 | Asynchronous write strobe, active low |
| hook_pin | input | 1 | Asynchronous hookswitch pin |
| hook_ie | input | 1 | Hookswitch interrupt enable |
| irq_n | input | 1 | Device interrupt line, active low |
| line_en | input | 1 | Line interface enabled |
| line_deact | input | 1 | Line interface is in its deactivated state |
| line_act_done | input | 1 | Line interface activation completed |
| mode_stat | output | 2 | Current level code |
| en_mux | output | 1 | Multiplexer enable |
| en_dlc | output | 1 | Data-link controller enable |
| en_audio | output | 1 | Audio processor enable |
| en_line | output | 1 | Line interface enable |
| en_regif | output | 1 | Register interface enable |
| pclk_run | output | 1 | Processor clock runs when 1, held high when 0 |
| osc_run | output | 1 | Oscillator runs when 1; crystal input ignored when 0 |
| dlc_stat_clr | output | 1 | One-cycle clear of data-link read-only status |
| act_irq | output | 1 | One-cycle activation interrupt |
| ser_drive | output | 1 | Output enable for serial frame sync and serial clock |

## Verification
The bench builds the block with CNT_W=4, so the countdown lasts 16 cycles and the exact boundary cycle of the clock stop is checked on every power-down entry instead of once. The short window lets the bench sweep all four mode codes against both values of the enable flag, all four chip-select and write-strobe combinations, both hookswitch enable values, and both ends of the two-stage stop, each with a fresh countdown.

// File: rtl/psq_pkg.sv
package psq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DATA  = 3'd1,
    ST_VOICE = 3'd2,
    ST_COUNT = 3'd3,
    ST_HALF  = 3'd4,
    ST_DOWN  = 3'd5
  } psq_state_e;

  localparam logic [1:0] CODE_DOWN  = 2'b00;
  localparam logic [1:0] CODE_IDLE  = 2'b01;
  localparam logic [1:0] CODE_DATA  = 2'b10;
  localparam logic [1:0] CODE_VOICE = 2'b11;

  typedef struct packed {
    logic [1:0] code;
    logic       mux;
    logic       dlc;
    logic       audio;
    logic       line;
    logic       regif;
    logic       pclk;
    logic       osc;
  } psq_outs_t;

endpackage

// File: rtl/psq_sync.sv
module psq_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= RST_VAL;
          else     chain[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= RST_VAL;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/psq_countdown.sv
module psq_countdown #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  output logic             done,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] TERM = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == TERM);
endmodule

// File: rtl/psq_fsm.sv
module psq_fsm
  import psq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_wr,
  input  logic [1:0]       mode_code,
  input  logic             pd_en,
  input  logic             irq_n,
  input  logic             line_en,
  input  logic             line_deact,
  input  logic             line_act_done,
  input  logic             wake,
  input  logic             cnt_done,
  input  logic [CNT_W-1:0] cnt,
  output psq_state_e       st,
  output psq_state_e       nxt
);
  localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE, ST_DATA, ST_VOICE: begin
        if (mode_wr) begin
          unique case (mode_code)
            CODE_VOICE: nxt = ST_VOICE;
            CODE_DATA:  nxt = ST_DATA;
            CODE_IDLE:  nxt = ST_IDLE;
            default:    nxt = pd_en ? ST_COUNT : st;
          endcase
        end
      end
      ST_COUNT: begin
        if (!irq_n)        nxt = ST_IDLE;
        else if (cnt_done) nxt = (line_en && !line_deact) ? ST_HALF : ST_DOWN;
      end
      ST_HALF: begin
        if (line_act_done)   nxt = ST_IDLE;
        else if (wake)       nxt = ST_IDLE;
        else if (line_deact) nxt = ST_DOWN;
      end
      ST_DOWN: begin
        if (wake) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= nxt;
  end

  AST_PD_GATED: assert property (@(posedge clk) disable iff (rst)
    (st == ST_COUNT && $past(st) != ST_COUNT) |-> $past(pd_en)); // R4
  AST_FULL_COUNT: assert property (@(posedge clk) disable iff (rst)
    (st == ST_COUNT && (nxt == ST_HALF || nxt == ST_DOWN)) |-> (cnt == LAST)); // R5
  AST_CANCEL: assert property (@(posedge clk) disable iff (rst)
    (st == ST_COUNT && !irq_n) |=> (st == ST_IDLE)); // R6
  AST_FROZEN_MODE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DOWN && !wake) |=> (st == ST_DOWN)); // R12
endmodule

// File: rtl/psq_outdec.sv
module psq_outdec
  import psq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  psq_state_e st,
  input  psq_state_e nxt,
  input  logic       line_act_done,
  output psq_outs_t  outs,
  output logic       dlc_stat_clr,
  output logic       act_irq
);
  psq_outs_t dec;

  always_comb begin
    dec = '{code: CODE_IDLE, mux: 1'b0, dlc: 1'b0, audio: 1'b0,
            line: 1'b1, regif: 1'b1, pclk: 1'b1, osc: 1'b1};
    unique case (nxt)
      ST_VOICE: begin
        dec.code = CODE_VOICE; dec.mux = 1'b1; dec.dlc = 1'b1; dec.audio = 1'b1;
      end
      ST_DATA: begin
        dec.code = CODE_DATA; dec.mux = 1'b1; dec.dlc = 1'b1;
      end
      ST_COUNT: dec.code = CODE_DOWN;
      ST_HALF: begin
        dec.code = CODE_DOWN; dec.regif = 1'b0; dec.pclk = 1'b0;
      end
      ST_DOWN: begin
        dec.code = CODE_DOWN; dec.regif = 1'b0; dec.pclk = 1'b0;
        dec.line = 1'b0; dec.osc = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outs         <= '{code: CODE_IDLE, mux: 1'b0, dlc: 1'b0, audio: 1'b0,
                        line: 1'b1, regif: 1'b1, pclk: 1'b1, osc: 1'b1};
      dlc_stat_clr <= 1'b0;
      act_irq      <= 1'b0;
    end else begin
      outs         <= dec;
      dlc_stat_clr <= (nxt == ST_IDLE) && (st != ST_IDLE);
      act_irq      <= (st == ST_HALF) && line_act_done;
    end
  end

  AST_CLR_ONE: assert property (@(posedge clk) disable iff (rst)
    dlc_stat_clr |=> !dlc_stat_clr); // R3
  AST_ACT_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    act_irq |-> (outs.code == CODE_IDLE)); // R8
  AST_STOP_ORDER: assert property (@(posedge clk) disable iff (rst)
    !outs.osc |-> !outs.pclk); // R7
endmodule

// File: rtl/psq_power_seq.sv
module psq_power_seq
  import psq_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int SYNC_ST = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_wr,
  input  logic [1:0] mode_code,
  input  logic       cfg_wr,
  input  logic       cfg_pd_en,
  input  logic       mux_conn_wr,
  input  logic       cs_n,
  input  logic       wr_n,
  input  logic       hook_pin,
  input  logic       hook_ie,
  input  logic       irq_n,
  input  logic       line_en,
  input  logic       line_deact,
  input  logic       line_act_done,
  output logic [1:0] mode_stat,
  output logic       en_mux,
  output logic       en_dlc,
  output logic       en_audio,
  output logic       en_line,
  output logic       en_regif,
  output logic       pclk_run,
  output logic       osc_run,
  output logic       dlc_stat_clr,
  output logic       act_irq,
  output logic       ser_drive
);
  localparam int NPIN = 3;

  logic [NPIN-1:0]  pins_s;
  logic             cs_s, wr_s, hook_s, hook_prev;
  logic             pd_en, wake, cnt_done;
  logic [CNT_W-1:0] cnt;
  psq_state_e       st, nxt;
  psq_outs_t        outs;

  psq_sync #(.WIDTH(NPIN), .STAGES(SYNC_ST), .RST_VAL(3'b110)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, wr_n, hook_pin}),
    .q   (pins_s)
  );
  assign {cs_s, wr_s, hook_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      hook_prev <= 1'b0;
      pd_en     <= 1'b0;
      ser_drive <= 1'b0;
    end else begin
      hook_prev <= hook_s;
      if (cfg_wr)      pd_en     <= cfg_pd_en;
      if (mux_conn_wr) ser_drive <= 1'b1;
    end
  end

  assign wake = (!cs_s && !wr_s) || (hook_ie && (hook_s != hook_prev));

  psq_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .run  (st == ST_COUNT),
    .done (cnt_done),
    .cnt  (cnt)
  );

  psq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .mode_wr       (mode_wr),
    .mode_code     (mode_code),
    .pd_en         (pd_en),
    .irq_n         (irq_n),
    .line_en       (line_en),
    .line_deact    (line_deact),
    .line_act_done (line_act_done),
    .wake          (wake),
    .cnt_done      (cnt_done),
    .cnt           (cnt),
    .st            (st),
    .nxt           (nxt)
  );

  psq_outdec u_dec (
    .clk           (clk),
    .rst           (rst),
    .st            (st),
    .nxt           (nxt),
    .line_act_done (line_act_done),
    .outs          (outs),
    .dlc_stat_clr  (dlc_stat_clr),
    .act_irq       (act_irq)
  );

  assign mode_stat = outs.code;
  assign en_mux    = outs.mux;
  assign en_dlc    = outs.dlc;
  assign en_audio  = outs.audio;
  assign en_line   = outs.line;
  assign en_regif  = outs.regif;
  assign pclk_run  = outs.pclk;
  assign osc_run   = outs.osc;

  AST_SER_STICKY: assert property (@(posedge clk) disable iff (rst)
    ser_drive |=> ser_drive); // R11
  AST_AUDIO_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
    en_audio |-> (mode_stat == CODE_VOICE)); // R2
endmodule

// File: tb/psq_power_seq_tb_top.sv
module psq_power_seq_tb_top;
  localparam int CNT_W = 4;
  localparam int TC    = 1 << CNT_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_wr = 0, cfg_wr = 0, cfg_pd_en = 0, mux_conn_wr = 0;
  logic [1:0] mode_code = 2'b01;
  logic cs_n = 1, wr_n = 1, hook_pin = 0, hook_ie = 0, irq_n = 1;
  logic line_en = 0, line_deact = 1, line_act_done = 0;
  logic [1:0] mode_stat;
  logic en_mux, en_dlc, en_audio, en_line, en_regif, pclk_run, osc_run;
  logic dlc_stat_clr, act_irq, ser_drive;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  psq_power_seq #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_code(mode_code),
    .cfg_wr(cfg_wr), .cfg_pd_en(cfg_pd_en), .mux_conn_wr(mux_conn_wr),
    .cs_n(cs_n), .wr_n(wr_n), .hook_pin(hook_pin), .hook_ie(hook_ie),
    .irq_n(irq_n), .line_en(line_en), .line_deact(line_deact),
    .line_act_done(line_act_done), .mode_stat(mode_stat), .en_mux(en_mux),
    .en_dlc(en_dlc), .en_audio(en_audio), .en_line(en_line),
    .en_regif(en_regif), .pclk_run(pclk_run), .osc_run(osc_run),
    .dlc_stat_clr(dlc_stat_clr), .act_irq(act_irq), .ser_drive(ser_drive)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_mode(input logic [1:0] code);
    @(negedge clk); mode_code = code; mode_wr = 1;
    @(negedge clk); mode_wr = 0;
  endtask

  task automatic write_cfg(input logic en);
    @(negedge clk); cfg_pd_en = en; cfg_wr = 1;
    @(negedge clk); cfg_wr = 0;
  endtask

  // enter countdown and run it to its end; checks exact boundary (R5)
  task automatic run_countdown();
    write_mode(2'b00);
    check("R5 status in countdown", mode_stat, 0);
    check("R5 pclk at start", pclk_run, 1);
    repeat (TC - 1) @(negedge clk);
    check("R5 pclk last count cycle", pclk_run, 1);
    @(negedge clk);
    check("R5 pclk held after count", pclk_run, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 mode", mode_stat, 1);
    check("R1 en_mux", en_mux, 0);
    check("R1 en_dlc", en_dlc, 0);
    check("R1 en_audio", en_audio, 0);
    check("R1 en_line", en_line, 1);
    check("R1 en_regif", en_regif, 1);
    check("R1 pclk", pclk_run, 1);
    check("R1 osc", osc_run, 1);
    check("R1 ser_drive", ser_drive, 0);

    // Sweep all codes x enable flag (R2, R3, R4, R6)
    for (int en = 0; en < 2; en++) begin
      for (int code = 0; code < 4; code++) begin
        write_cfg(en[0]);
        write_mode(code[1:0]);
        if (code == 0) begin
          check("R4 pd request", mode_stat, en ? 0 : 1);
          check("R3 no clr in idle", dlc_stat_clr, 0);
          if (en) begin
            repeat (3) @(negedge clk);
            write_mode(2'b11); // R12 ignored during countdown
            check("R12 write during countdown", mode_stat, 0);
            @(negedge clk); irq_n = 0;
            @(negedge clk); irq_n = 1;
            check("R6 cancel to idle", mode_stat, 1);
            check("R6 pclk", pclk_run, 1);
            check("R3 clr pulse on cancel", dlc_stat_clr, 1);
            @(negedge clk);
            check("R3 clr one cycle", dlc_stat_clr, 0);
          end
        end else begin
          check("R2 mode code", mode_stat, code);
          check("R2 en_audio", en_audio, code == 3);
          check("R2 en_dlc", en_dlc, code >= 2);
          check("R2 en_mux", en_mux, code >= 2);
          check("R3 clr", dlc_stat_clr, 0);
          if (code >= 2) begin
            write_mode(2'b01);
            check("R3 clr on idle entry", dlc_stat_clr, 1);
            @(negedge clk);
            check("R3 clr one cycle", dlc_stat_clr, 0);
          end
        end
      end
    end

    // Full stop and chip-select/write wake sweep (R5, R9, R12)
    write_cfg(1);
    line_en = 0;
    for (int combo = 0; combo < 4; combo++) begin
      run_countdown();
      check("R5 osc stopped", osc_run, 0);
      write_mode(2'b11);
      check("R12 write in power-down", mode_stat, 0);
      @(negedge clk); cs_n = combo[0]; wr_n = combo[1];
      repeat (4) @(negedge clk);
      check("R9 wake combo", mode_stat, (combo == 0) ? 1 : 0);
      cs_n = 1; wr_n = 1;
      if (combo != 0) begin
        @(negedge clk); cs_n = 0; wr_n = 0;
        repeat (4) @(negedge clk);
        cs_n = 1; wr_n = 1;
        check("R9 wake both low", mode_stat, 1);
      end
      repeat (3) @(negedge clk);
    end

    // Two-stage stop, then deactivation (R7) and hookswitch wake (R10)
    line_en = 1; line_deact = 0;
    run_countdown();
    check("R7 osc keeps running", osc_run, 1);
    check("R7 status", mode_stat, 0);
    line_deact = 1;
    @(negedge clk);
    check("R7 osc stops after deact", osc_run, 0);
    for (int ie = 0; ie < 2; ie++) begin
      hook_ie = ie[0];
      hook_pin = ~hook_pin;
      repeat (4) @(negedge clk);
      check("R10 hook wake", mode_stat, ie ? 1 : 0);
    end
    hook_ie = 0;

    // Two-stage stop ending in activation (R8)
    line_deact = 0;
    run_countdown();
    check("R8 osc running", osc_run, 1);
    line_act_done = 1;
    @(negedge clk); line_act_done = 0;
    check("R8 act irq", act_irq, 1);
    check("R8 back to idle", mode_stat, 1);
    check("R8 pclk", pclk_run, 1);
    @(negedge clk);
    check("R8 irq one cycle", act_irq, 0);

    // Serial drive enable (R11)
    check("R11 before mux write", ser_drive, 0);
    @(negedge clk); mux_conn_wr = 1;
    @(negedge clk); mux_conn_wr = 0;
    check("R11 after mux write", ser_drive, 1);
    repeat (5) @(negedge clk);
    check("R11 sticky", ser_drive, 1);
    rst = 1;
    @(negedge clk); rst = 0;
    check("R11 cleared by reset", ser_drive, 0);
    check("R1 mode after reset", mode_stat, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule